// File: doc/BRIEF.md
# Debounced Level Interrupt Channel Bank

This block watches eight external input pins and turns each into a clean, filtered level that software can read and use as an interrupt source. Each pin first passes through a two-flop synchronizer. A per-channel counter then adopts a new value only after the pin has held it for a programmable number of millisecond ticks. The resulting debounced level is compared against a per-channel polarity. When the channel is enabled, its interrupt is enabled and its single-shot trigger is armed, the block records a pending status bit.

Software controls the bank through a simple register port: address, write data, write strobe and combinational read data. Pending bits are cleared by writing ones. The single-shot arm drops by itself each time a channel fires, so software re-arms the channel after it services the interrupt. One interrupt output is asserted whenever any enabled channel has a pending bit.

Top module: `dbnc_irq_bank`

## Requirements
- R1: Register offsets (bit n of each vector register belongs to channel n, bits above 7 read 0): 0x00 filtered levels (read only), 0x04 channel enable, 0x14 polarity, 0x18 interrupt enable, 0x1C pending status (read only), 0x20 pending status AND interrupt enable (read only), 0x24 clear (write-one, reads 0), 0x28 single-shot arm, and 0x40 + 4*n the filter period of channel n.
- R2: After reset, every vector register reads 0, every filter period word reads 1, and the interrupt output is low.
- R3: A filter period word keeps bits [11:0] of a write and reads 0 in bits [31:12].
- R4: The filtered level of an enabled channel takes the pin's new value on the P-th millisecond tick that arrives while the synchronized pin differs from it, where P is the channel's period field and a field of 0 acts as 1.
- R5: If the synchronized pin returns to the filtered level before the P-th tick, the count is discarded, and a later change needs a full P ticks again.
- R6: Without millisecond ticks, the filtered level does not change, however long the pin holds a new value.
- R7: A channel fires when it is enabled, its interrupt is enabled, it is armed and its filtered level equals its polarity bit (1 = active high, 0 = active low). On the next clock its pending bit is 1 and its arm bit is 0.
- R8: With its interrupt enable at 0, an armed channel at its active level does not fire, and its arm bit stays 1.
- R9: Writing a 1 to a clear bit drops that channel's pending bit and leaves the others. A pending bit that was cleared stays 0 at an active level until the channel is re-armed.
- R10: The interrupt output is high exactly when some pending bit has its interrupt enable set. Clearing the enable hides a pending bit without dropping it.
- R11: A channel whose enable bit is 0 reads 0 as its filtered level. After it is enabled again, it needs a full period to follow the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| pin_i | input | 8 | Asynchronous channel inputs |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
The filter assertions assume the millisecond tick is a synchronous single-cycle pulse. They also assume the channel enable reaching each filter comes from a register, so that a stable level between ticks is meaningful. The status assertions assume that a write strobe is sampled only on a clock edge, with address and data steady around it. The stimulus changes the pins, the tick, the strobe and the bus fields only at falling edges. It pulses the tick for exactly one cycle, and it waits three clocks after a pin change before issuing ticks, so that the synchronizer has settled when counting starts.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_CHEN  = 32'h04;
  localparam int unsigned OFS_POL   = 32'h14;
  localparam int unsigned OFS_IEN   = 32'h18;
  localparam int unsigned OFS_PEND  = 32'h1C;
  localparam int unsigned OFS_MPEND = 32'h20;
  localparam int unsigned OFS_CLR   = 32'h24;
  localparam int unsigned OFS_ARM   = 32'h28;
  localparam int unsigned OFS_PER0  = 32'h40;

  // byte address of the period word of channel ch
  function automatic int unsigned period_ofs(input int unsigned ch);
    return OFS_PER0 + 4 * ch;
  endfunction

  // 1 when the filtered level matches the programmed polarity
  function automatic logic level_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          in_i,
  input  logic [CW-1:0] period_i,
  output logic          level_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  // a programmed period of zero behaves as one tick
  function automatic logic [CW-1:0] eff_limit(input logic [CW-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          differs_w;
  logic          commit_w;
  logic [CW-1:0] limit_w;

  assign limit_w   = eff_limit(period_i);
  assign differs_w = in_i != lvl_q;
  assign commit_w  = tick_i && differs_w && (cnt_q >= limit_w - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!differs_w) begin
      cnt_q <= '0;
    end else if (commit_w) begin
      cnt_q <= '0;
      lvl_q <= in_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign level_o = lvl_q;

  // R6: level holds between ticks
  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(lvl_q));

  // R5: agreement with the pin discards any partial count
  a_r5_restart_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !differs_w) |=> (cnt_q == '0));

  // R11: a disabled channel reads low
  a_r11_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lvl_q && cnt_q == '0));
endmodule

// File: rtl/dbnc_irq_bank.sv
module dbnc_irq_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned PW  = 12,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ms_tick_i,
  input  logic [7:0]    pin_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  import dbnc_pkg::*;

  localparam logic [PW-1:0] PER_RST = {{(PW-1){1'b0}}, 1'b1};

  logic [NCH-1:0] chen_q, pol_q, ien_q, arm_q, pend_q;
  logic [PW-1:0]  per_q [NCH];
  logic [NCH-1:0] sync_w, level_w, active_w, fire_w, clr_w, masked_w;
  logic [NCH-1:0] pend_d, arm_d;
  logic [31:0]    addr32_w;
  logic           unused_wdata;

  assign addr32_w     = 32'(addr_i);
  assign unused_wdata = ^wdata_i[DW-1:PW];

  function automatic logic hit(input logic [31:0] a, input int unsigned ofs);
    return a == ofs;
  endfunction

  dbnc_sync #(.W(NCH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i[NCH-1:0]),
    .q_o    (sync_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dbnc_filter #(.CW(PW)) u_flt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (chen_q[i]),
      .tick_i   (ms_tick_i),
      .in_i     (sync_w[i]),
      .period_i (per_q[i]),
      .level_o  (level_w[i])
    );

    assign active_w[i] = level_active(level_w[i], pol_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q[i] <= PER_RST;
      else if (we_i && hit(addr32_w, period_ofs(i))) per_q[i] <= wdata_i[PW-1:0];
    end
  end

  // events between the filters and the status logic
  assign fire_w   = chen_q & ien_q & arm_q & active_w;
  assign clr_w    = (we_i && hit(addr32_w, OFS_CLR)) ? wdata_i[NCH-1:0] : '0;
  assign pend_d   = (pend_q & ~clr_w) | fire_w;
  assign arm_d    = ((we_i && hit(addr32_w, OFS_ARM)) ? wdata_i[NCH-1:0] : arm_q) & ~fire_w;
  assign masked_w = pend_q & ien_q;
  assign irq_o    = |masked_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chen_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      arm_q  <= '0;
      pend_q <= '0;
    end else begin
      if (we_i && hit(addr32_w, OFS_CHEN)) chen_q <= wdata_i[NCH-1:0];
      if (we_i && hit(addr32_w, OFS_POL))  pol_q  <= wdata_i[NCH-1:0];
      if (we_i && hit(addr32_w, OFS_IEN))  ien_q  <= wdata_i[NCH-1:0];
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr32_w, OFS_LEVEL)) rdata_o[NCH-1:0] = level_w;
    if (hit(addr32_w, OFS_CHEN))  rdata_o[NCH-1:0] = chen_q;
    if (hit(addr32_w, OFS_POL))   rdata_o[NCH-1:0] = pol_q;
    if (hit(addr32_w, OFS_IEN))   rdata_o[NCH-1:0] = ien_q;
    if (hit(addr32_w, OFS_PEND))  rdata_o[NCH-1:0] = pend_q;
    if (hit(addr32_w, OFS_MPEND)) rdata_o[NCH-1:0] = masked_w;
    if (hit(addr32_w, OFS_ARM))   rdata_o[NCH-1:0] = arm_q;
    for (int i = 0; i < NCH; i++) begin
      if (hit(addr32_w, period_ofs(i))) rdata_o[PW-1:0] = per_q[i];
    end
  end

  // R7: a firing channel becomes pending and is disarmed
  a_r7_fire_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire_w) |=> (((pend_q & $past(fire_w)) == $past(fire_w)) &&
                   ((arm_q & $past(fire_w)) == '0)));

  // R8: a new pending bit needs enable, interrupt enable and arm
  a_r8_pending_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(chen_q & ien_q & arm_q)) == '0));

  // R9: a cleared bit that is not firing is gone next cycle
  a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_w & ~fire_w) != '0) |=> ((pend_q & $past(clr_w & ~fire_w)) == '0));

  // R10: nothing enabled, no interrupt
  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/tb_dbnc_irq_bank.sv
module tb_dbnc_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  pins = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  dbnc_irq_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .pin_i(pins),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); pins[ch] = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0] regs [7] = '{8'h00, 8'h04, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28};
    foreach (regs[k]) begin rd(regs[k], v); chk("R2 vector reg reset", v, 0); end
    for (int c = 0; c < 8; c++) begin rd(8'(8'h40 + 4 * c), v); chk("R2 period reset", v, 1); end
    chk("R2 irq reset", {31'b0, irq}, 0);
  endtask

  task automatic t_period_field();
    logic [31:0] v;
    wr(8'h48, 32'hABCDE005);
    rd(8'h48, v); chk("R3 period field masking", v, 32'h005);
    wr(8'h40, 3);
    rd(8'h40, v); chk("R3 period readback", v, 3);
    wr(8'h54, 0);
    rd(8'h54, v); chk("R3 period zero stored", v, 0);
  endtask

  task automatic t_debounce();
    logic [31:0] v;
    wr(8'h04, 32'h01);
    set_pin(0, 1'b1);
    rd(8'h00, v); chk("R4 before ticks", v, 0);
    pulse_ticks(2);
    rd(8'h00, v); chk("R4 after P-1 ticks", v, 0);
    pulse_ticks(1);
    rd(8'h00, v); chk("R4 after P ticks", v, 1);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    set_pin(0, 1'b0);
    pulse_ticks(2);
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    pulse_ticks(2);
    rd(8'h00, v); chk("R5 count discarded", v, 1);
    pulse_ticks(1);
    rd(8'h00, v); chk("R5 full period after restart", v, 0);
    set_pin(0, 1'b1);
    pulse_ticks(3);
    rd(8'h00, v); chk("R4 rising again", v, 1);
  endtask

  task automatic t_no_tick();
    logic [31:0] v;
    set_pin(0, 1'b0);
    repeat (40) @(posedge clk);
    rd(8'h00, v); chk("R6 no change without ticks", v, 1);
    set_pin(0, 1'b1);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    wr(8'h14, 32'h01);
    wr(8'h18, 32'h01);
    chk("R10 irq low before arm", {31'b0, irq}, 0);
    wr(8'h28, 32'h01);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R7 pending set", v, 1);
    rd(8'h20, v); chk("R10 masked pending", v, 1);
    rd(8'h28, v); chk("R7 arm consumed", v, 0);
    chk("R10 irq high", {31'b0, irq}, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h24, 32'h01);
    repeat (5) @(negedge clk);
    rd(8'h1C, v); chk("R9 cleared stays clear unarmed", v, 0);
    chk("R9 irq low after clear", {31'b0, irq}, 0);
    rd(8'h24, v); chk("R1 clear reads zero", v, 0);
    wr(8'h28, 32'h01);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R9 re-arm fires again", v, 1);
    wr(8'h24, 32'h01);
  endtask

  task automatic t_ien_gate();
    logic [31:0] v;
    wr(8'h18, 32'h00);
    wr(8'h28, 32'h01);
    repeat (3) @(negedge clk);
    rd(8'h1C, v); chk("R8 no fire without interrupt enable", v, 0);
    rd(8'h28, v); chk("R8 arm kept", v, 1);
    wr(8'h18, 32'h01);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R7 fires once enabled", v, 1);
    wr(8'h18, 32'h00);
    repeat (2) @(negedge clk);
    rd(8'h20, v); chk("R10 masked hidden", v, 0);
    rd(8'h1C, v); chk("R10 pending kept", v, 1);
    chk("R10 irq hidden", {31'b0, irq}, 0);
    wr(8'h24, 32'h01);
  endtask

  task automatic t_active_low();
    logic [31:0] v;
    wr(8'h04, 32'h21);
    wr(8'h18, 32'h21);
    wr(8'h28, 32'h20);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R7 active-low fires", v, 32'h20);
    rd(8'h20, v); chk("R10 masked active-low", v, 32'h20);
    chk("R10 irq active-low", {31'b0, irq}, 1);
    wr(8'h24, 32'h01);
    rd(8'h1C, v); chk("R9 other bit untouched", v, 32'h20);
    wr(8'h24, 32'h20);
    rd(8'h1C, v); chk("R9 selected bit cleared", v, 0);
    set_pin(5, 1'b1);
    pulse_ticks(1);
    rd(8'h00, v); chk("R4 zero period acts as one", v, 32'h21);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(8'h04, 32'h20);
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R11 disabled reads low", v, 32'h20);
    wr(8'h04, 32'h21);
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R11 re-enabled needs period", v, 32'h20);
    pulse_ticks(3);
    rd(8'h00, v); chk("R11 follows after period", v, 32'h21);
    rd(8'h04, v); chk("R1 enable readback", v, 32'h21);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period_field();
    t_debounce();
    t_restart();
    t_no_tick();
    t_level_high();
    t_clear();
    t_ien_gate();
    t_active_low();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule